// File: doc/BRIEF.md
# Backplane Bus Requester with Deferred Request Level

This block is the bus requester for a DMA engine on a backplane bus. The bus has four prioritised request/grant pairs and one shared busy line. When the DMA engine or software wants the bus, the block raises the request line of its active level and waits for the grant on that same level while the bus is idle. It then drops the request and drives busy in one step. Later it gives the bus up according to a programmed release mode and the FIFO state. A software wait-for-bus bit lets firmware claim the bus. A hold status bit reports when that claim has been met. An optional fair mode keeps the requester from piling onto a request line that another master is already using.

The request level software programs does not take effect at once. The requester keeps a separate active level. That active level is loaded from the programmed value only at the moment the bus is won. So after a change, one more request goes out at the old level, and the new level applies from then on. After reset the active level is 3.

Top module: `dma_bus_requester`

## Requirements
- R1: After reset, no request line is driven, busy is low, hold is low and the active level reads 3.
- R2: Every request drives exactly one request line, the one at bit position equal to the active level. The first request after reset uses line 3 whatever the programmed level is.
- R3: Mastership is taken only when the grant bit at the active level is high and the busy input is low. In the cycle after that edge the request line is low and busy out is high. A grant on any other bit is ignored.
- R4: At the edge where mastership is taken, the active level is loaded from the programmed level. It changes at no other time.
- R5: If the programmed level changes while the block is master, the next request still uses the old level. The new level applies from the following mastership onward.
- R6: Once busy out rises, it stays high for at least two clock cycles, whatever release conditions appear.
- R7: While master and with wait-for-bus low, the bus is released in these two cases, whatever the release mode is: the direction input is 1 (bus to local) and FIFO full is high, or the direction is 0 and FIFO empty is high. FIFO full with direction 0 does not release.
- R8: The release mode sets when the bus is released. 00 releases on transfer done. 01 releases when any request line input is high. 10 releases on bus clear. 11 releases on done or on any request line input. All other inputs have no effect on release.
- R9: While wait-for-bus is high, the block requests the bus. Hold reads 1 from the cycle after the bus is won until wait-for-bus is cleared, and no release takes place meanwhile. After wait-for-bus is cleared, hold goes to 0 and release follows R7 and R8.
- R10: With fair mode on, a new request is not raised while the request line input at the active level is high. It is raised once that line goes low. Activity on other lines does not block it.
- R11: If both transfer request and wait-for-bus go low before a grant arrives, the request line is dropped on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progLevel | input | 2 | Programmed request level |
| relMode | input | 2 | Release mode select |
| fairEn | input | 1 | Fair request mode enable |
| waitBus | input | 1 | Software wait-for-bus bit |
| holdBus | output | 1 | Bus held in response to wait-for-bus |
| xferReq | input | 1 | DMA engine wants the bus |
| xferDone | input | 1 | DMA transfer complete |
| fifoFull | input | 1 | DMA FIFO full |
| fifoEmpty | input | 1 | DMA FIFO empty |
| dirToLocal | input | 1 | 1 = bus to local, 0 = local to bus |
| busReqIn | input | 4 | Observed bus request lines |
| busGrant | input | 4 | Bus grant inputs, one per level |
| busBusyIn | input | 1 | Observed bus busy |
| busClear | input | 1 | Bus clear indication from the arbiter |
| busReqOut | output | 4 | Driven bus request lines |
| busBusyOut | output | 1 | Driven bus busy (mastership) |
| activeLevel | output | 2 | Level currently used for requests |

## Verification
The bench programs a level different from 3 right after reset. A design that loaded the level at once would raise line 1 instead of line 3. It then changes the programmed level during a mastership and checks that one more request goes out at the old level. A design that adopted the level on release or at request time would move one request too early. Release conditions are applied in the very first mastership cycle. A design without the minimum busy time would drop busy after one clock. FIFO full is applied with the wrong direction, and each release mode gets the stimulus that must not release it. This catches swapped FIFO flags or mode encodings. Wait-for-bus is held across a done pulse, and fair mode is tried against a busy own-level line and a busy foreign line. This catches a hold that still releases and a fairness check on the wrong line.

// File: rtl/busreq_pkg.sv
package busreq_pkg;
  localparam int NUM_LEVELS = 4;
  localparam int LVL_W      = $clog2(NUM_LEVELS);

  typedef enum logic [1:0] {
    REL_ON_DONE   = 2'b00,
    REL_ON_OTHER  = 2'b01,
    REL_ON_CLEAR  = 2'b10,
    REL_ON_EITHER = 2'b11
  } relMode_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_GRAB,
    ST_OWN
  } reqState_t;

  typedef struct packed {
    logic reqEnable;
    logic takeBus;
  } ctlStrobes_t;

  typedef struct packed {
    logic fairBlocked;
    logic grantSeen;
    logic releaseCond;
  } dpStatus_t;
endpackage

// File: rtl/busreq_datapath.sv
module busreq_datapath
  import busreq_pkg::*;
#(
  parameter int LEVELS   = NUM_LEVELS,
  localparam int LW      = $clog2(LEVELS),
  localparam int RST_LVL = LEVELS - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LW-1:0]     progLevel,
  input  logic [1:0]        relMode,
  input  logic              fairEn,
  input  logic              xferDone,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              dirToLocal,
  input  logic [LEVELS-1:0] busReqIn,
  input  logic [LEVELS-1:0] busGrant,
  input  logic              busBusyIn,
  input  logic              busClear,
  input  ctlStrobes_t       strobes,
  output dpStatus_t         status,
  output logic [LEVELS-1:0] busReqOut,
  output logic [LW-1:0]     activeLevel
);

  logic [LW-1:0]     levelQ;
  logic [LEVELS-1:0] grantHit;
  logic [LEVELS-1:0] ownLineBusy;
  logic              otherReq;
  logic              fifoRel;
  logic              modeRel;

  always_ff @(posedge clk) begin
    if (!rstN) levelQ <= LW'(RST_LVL);
    else if (strobes.takeBus) levelQ <= progLevel;
  end

  assign activeLevel = levelQ;

  for (genvar i = 0; i < LEVELS; i++) begin : g_line
    assign busReqOut[i]   = strobes.reqEnable && (levelQ == LW'(i));
    assign grantHit[i]    = busGrant[i] && (levelQ == LW'(i));
    assign ownLineBusy[i] = busReqIn[i] && (levelQ == LW'(i));
  end

  assign otherReq = |busReqIn;
  assign fifoRel  = dirToLocal ? fifoFull : fifoEmpty;

  always_comb begin
    unique case (relMode_t'(relMode))
      REL_ON_DONE:   modeRel = xferDone;
      REL_ON_OTHER:  modeRel = otherReq;
      REL_ON_CLEAR:  modeRel = busClear;
      REL_ON_EITHER: modeRel = xferDone || otherReq;
      default:       modeRel = 1'b0;
    endcase
  end

  assign status.fairBlocked = fairEn && (|ownLineBusy);
  assign status.grantSeen   = (|grantHit) && !busBusyIn;
  assign status.releaseCond = fifoRel || modeRel;

  assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busReqOut));

  assert_take_needs_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeBus |-> (busGrant[levelQ] && !busBusyIn));

  assert_level_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeBus |=> (activeLevel == $past(progLevel)));

  assert_level_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.takeBus |=> $stable(activeLevel));

  assert_fair_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|busReqOut) |-> !($past(fairEn) && $past(busReqIn[activeLevel])));

endmodule

// File: rtl/busreq_control.sv
module busreq_control
  import busreq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferReq,
  input  logic        waitBus,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        busBusyOut,
  output logic        holdBus
);

  reqState_t state, nextState;
  logic      want;
  logic      holdQ;

  assign want = xferReq || waitBus;

  always_comb begin
    nextState         = state;
    strobes.reqEnable = 1'b0;
    strobes.takeBus   = 1'b0;
    unique case (state)
      ST_IDLE: if (want && !status.fairBlocked) nextState = ST_REQ;
      ST_REQ: begin
        strobes.reqEnable = 1'b1;
        if (!want) nextState = ST_IDLE;
        else if (status.grantSeen) begin
          strobes.takeBus = 1'b1;
          nextState       = ST_GRAB;
        end
      end
      ST_GRAB: nextState = ST_OWN;
      ST_OWN:  if (!waitBus && status.releaseCond) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      holdQ <= 1'b0;
    end else begin
      state <= nextState;
      holdQ <= waitBus && (strobes.takeBus || state == ST_GRAB || state == ST_OWN);
    end
  end

  assign busBusyOut = (state == ST_GRAB) || (state == ST_OWN);
  assign holdBus    = holdQ;

  assert_busy_min_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusyOut) |=> busBusyOut);

  assert_no_req_while_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.reqEnable && busBusyOut));

  assert_hold_means_master_R9: assert property (@(posedge clk) disable iff (!rstN)
    holdBus |-> busBusyOut);

  assert_wait_keeps_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OWN && waitBus) |=> busBusyOut);

  assert_drop_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.reqEnable && !xferReq && !waitBus) |=> !strobes.reqEnable);

endmodule

// File: rtl/dma_bus_requester.sv
module dma_bus_requester
  import busreq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LVL_W-1:0]      progLevel,
  input  logic [1:0]            relMode,
  input  logic                  fairEn,
  input  logic                  waitBus,
  output logic                  holdBus,
  input  logic                  xferReq,
  input  logic                  xferDone,
  input  logic                  fifoFull,
  input  logic                  fifoEmpty,
  input  logic                  dirToLocal,
  input  logic [NUM_LEVELS-1:0] busReqIn,
  input  logic [NUM_LEVELS-1:0] busGrant,
  input  logic                  busBusyIn,
  input  logic                  busClear,
  output logic [NUM_LEVELS-1:0] busReqOut,
  output logic                  busBusyOut,
  output logic [LVL_W-1:0]      activeLevel
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  busreq_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .xferReq    (xferReq),
    .waitBus    (waitBus),
    .status     (status),
    .strobes    (strobes),
    .busBusyOut (busBusyOut),
    .holdBus    (holdBus)
  );

  busreq_datapath #(.LEVELS(NUM_LEVELS)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .progLevel   (progLevel),
    .relMode     (relMode),
    .fairEn      (fairEn),
    .xferDone    (xferDone),
    .fifoFull    (fifoFull),
    .fifoEmpty   (fifoEmpty),
    .dirToLocal  (dirToLocal),
    .busReqIn    (busReqIn),
    .busGrant    (busGrant),
    .busBusyIn   (busBusyIn),
    .busClear    (busClear),
    .strobes     (strobes),
    .status      (status),
    .busReqOut   (busReqOut),
    .activeLevel (activeLevel)
  );

endmodule

// File: tb/test_dma_bus_requester.sv
module test_dma_bus_requester;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] progLevel, relMode, activeLevel;
  logic       fairEn, waitBus, holdBus, xferReq, xferDone;
  logic       fifoFull, fifoEmpty, dirToLocal, busBusyIn, busClear, busBusyOut;
  logic [3:0] busReqIn, busGrant, busReqOut;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dma_bus_requester i_dma_bus_requester (
    .clk(clk), .rstN(rstN), .progLevel(progLevel), .relMode(relMode),
    .fairEn(fairEn), .waitBus(waitBus), .holdBus(holdBus), .xferReq(xferReq),
    .xferDone(xferDone), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .dirToLocal(dirToLocal), .busReqIn(busReqIn), .busGrant(busGrant),
    .busBusyIn(busBusyIn), .busClear(busClear), .busReqOut(busReqOut),
    .busBusyOut(busBusyOut), .activeLevel(activeLevel)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic acquire(input int lvl);
    xferReq = 1'b1;
    tick();
    busGrant = 4'(1 << lvl);
    tick();
    busGrant = 4'b0;
    xferReq  = 1'b0;
    tick();
  endtask

  task automatic testReset();
    rstN = 1'b0; progLevel = 2'd1; relMode = 2'd0; fairEn = 1'b0; waitBus = 1'b0;
    xferReq = 1'b0; xferDone = 1'b0; fifoFull = 1'b0; fifoEmpty = 1'b0;
    dirToLocal = 1'b0; busReqIn = 4'b0; busGrant = 4'b0; busBusyIn = 1'b0; busClear = 1'b0;
    repeat (3) tick();
    chk("R1", "busReqOut", busReqOut, 0);
    chk("R1", "busBusyOut", busBusyOut, 0);
    chk("R1", "holdBus", holdBus, 0);
    chk("R1", "activeLevel", activeLevel, 3);
    rstN = 1'b1;
    tick();
  endtask

  task automatic testFirstGrant();
    xferReq = 1'b1;
    tick();
    chk("R2", "first request line", busReqOut, 8);
    busGrant = 4'b0010;
    tick();
    chk("R3", "foreign grant req", busReqOut, 8);
    chk("R3", "foreign grant busy", busBusyOut, 0);
    busGrant = 4'b1000; busBusyIn = 1'b1;
    tick();
    chk("R3", "busy-in blocks take", busBusyOut, 0);
    busBusyIn = 1'b0;
    tick();
    chk("R3", "req dropped at take", busReqOut, 0);
    chk("R3", "busy driven at take", busBusyOut, 1);
    chk("R4", "level loaded at take", activeLevel, 1);
    busGrant = 4'b0; xferReq = 1'b0; xferDone = 1'b1;
    tick();
    chk("R6", "busy minimum time", busBusyOut, 1);
    tick();
    chk("R8", "mode 00 releases on done", busBusyOut, 0);
    xferDone = 1'b0;
  endtask

  task automatic testDeferredLevel();
    xferReq = 1'b1;
    tick();
    chk("R4", "request at new level", busReqOut, 2);
    busGrant = 4'b0010;
    tick();
    busGrant = 4'b0;
    progLevel = 2'd2;
    tick();
    xferDone = 1'b1;
    tick();
    xferDone = 1'b0;
    chk("R5", "released", busBusyOut, 0);
    tick();
    chk("R5", "old level after change", busReqOut, 2);
    chk("R5", "level not yet adopted", activeLevel, 1);
    busGrant = 4'b0010;
    tick();
    busGrant = 4'b0;
    chk("R5", "level adopted at grant", activeLevel, 2);
    xferDone = 1'b1;
    tick();
    tick();
    xferDone = 1'b0;
    tick();
    chk("R5", "new level used", busReqOut, 4);
    xferReq = 1'b0;
    tick();
    chk("R11", "request withdrawn", busReqOut, 0);
  endtask

  task automatic testFifoRelease();
    relMode = 2'd2;
    acquire(2);
    dirToLocal = 1'b0; fifoFull = 1'b1;
    tick();
    chk("R7", "full with dir 0 keeps bus", busBusyOut, 1);
    fifoFull = 1'b0; fifoEmpty = 1'b1;
    tick();
    chk("R7", "empty with dir 0 releases", busBusyOut, 0);
    fifoEmpty = 1'b0;
    acquire(2);
    dirToLocal = 1'b1; fifoFull = 1'b1;
    tick();
    chk("R7", "full with dir 1 releases", busBusyOut, 0);
    fifoFull = 1'b0; dirToLocal = 1'b0;
  endtask

  task automatic testModes();
    relMode = 2'd1;
    acquire(2);
    busClear = 1'b1; tick();
    chk("R8", "mode 01 ignores clear", busBusyOut, 1);
    busClear = 1'b0; busReqIn = 4'b0001; tick();
    chk("R8", "mode 01 releases on request", busBusyOut, 0);
    busReqIn = 4'b0;
    relMode = 2'd2;
    acquire(2);
    busReqIn = 4'b0001; tick();
    chk("R8", "mode 10 ignores request", busBusyOut, 1);
    busReqIn = 4'b0; busClear = 1'b1; tick();
    chk("R8", "mode 10 releases on clear", busBusyOut, 0);
    busClear = 1'b0;
    relMode = 2'd3;
    acquire(2);
    busClear = 1'b1; tick();
    chk("R8", "mode 11 ignores clear", busBusyOut, 1);
    busClear = 1'b0; xferDone = 1'b1; tick();
    chk("R8", "mode 11 releases on done", busBusyOut, 0);
    xferDone = 1'b0;
    acquire(2);
    busReqIn = 4'b0010; tick();
    chk("R8", "mode 11 releases on request", busBusyOut, 0);
    busReqIn = 4'b0;
    relMode = 2'd0;
    acquire(2);
    busReqIn = 4'b0001; tick();
    chk("R8", "mode 00 ignores request", busBusyOut, 1);
    busReqIn = 4'b0; xferDone = 1'b1; tick();
    chk("R8", "mode 00 releases on done", busBusyOut, 0);
    xferDone = 1'b0;
  endtask

  task automatic testWaitHold();
    waitBus = 1'b1;
    tick();
    chk("R9", "wait-for-bus requests", busReqOut, 4);
    busGrant = 4'b0100;
    tick();
    busGrant = 4'b0;
    chk("R9", "hold set", holdBus, 1);
    tick();
    xferDone = 1'b1;
    tick();
    chk("R9", "held despite done", busBusyOut, 1);
    xferDone = 1'b0; waitBus = 1'b0;
    tick();
    chk("R9", "hold cleared", holdBus, 0);
    chk("R9", "bus kept until mode condition", busBusyOut, 1);
    xferDone = 1'b1;
    tick();
    chk("R9", "release by mode", busBusyOut, 0);
    xferDone = 1'b0;
  endtask

  task automatic testFair();
    fairEn = 1'b1; busReqIn = 4'b0100; xferReq = 1'b1;
    tick(); tick();
    chk("R10", "own line busy blocks", busReqOut, 0);
    busReqIn = 4'b0;
    tick();
    chk("R10", "request after line idle", busReqOut, 4);
    xferReq = 1'b0;
    tick();
    busReqIn = 4'b0001; xferReq = 1'b1;
    tick();
    chk("R10", "other line does not block", busReqOut, 4);
    xferReq = 1'b0; busReqIn = 4'b0; fairEn = 1'b0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testFirstGrant();
    testDeferredLevel();
    testFifoRelease();
    testModes();
    testWaitHold();
    testFair();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule